// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store pipeline and a 32-bit memory bus that only takes naturally aligned transfers. It accepts one single-register request (byte, halfword or word; read or write) at any byte address. It then issues a back-to-back series of aligned bus transfers that together cover exactly the requested bytes. Splitting follows a fixed table per size and offset, so a misaligned word takes at most three bus cycles built from byte and halfword pieces.

For writes, each piece places the proper bytes of the right-justified store value on the byte lanes that match its address, in big-endian order. For reads, the bytes returned by each piece are gathered into one right-justified, zero-extended result. That result is presented with a one-cycle completion response, which also reports whether any piece ended in a bus error. Every bus cycle carries a speculation flag. This flag clears once the owning instruction is declared nonspeculative through a commit pulse. A request marked as needing nonspeculative treatment keeps the bus idle until that happens.

Top module: `misalign_splitter`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: Size encodings are 0 = byte, 1 = halfword, 2 = word; 3 is treated as word. A byte at any offset, a halfword at address bits [1:0] = 0 or 2, and a word at offset 0 each go out as one bus transfer with the request's address and size. Every bus transfer is naturally aligned.
- R3: A halfword at offset 1 or 3 goes out as two byte transfers, at the request address and then at the request address plus one. At offset 3 the second transfer falls in the next word.
- R4: A word at offset 2 goes out as two halfword transfers, at the request address and then at the request address plus two.
- R5: A word at offset 1 or 3 goes out as three transfers: a byte at the request address, a halfword at the address plus one, and a byte at the address plus three.
- R6: For a write, bus_write is 1 on every piece. The request byte at relative position k (0 = lowest address) is taken from req_wdata bits [8*(N-1-k)+7 : 8*(N-1-k)], where N is the request size in bytes. It is driven on the lane of its own address, and the lane for address bits [1:0] = 0 is bus_wdata[31:24].
- R7: For a read, rsp_rdata holds the N requested bytes right-justified, with the lowest address as the most significant byte. It is zero-extended above N bytes. Lane use on bus_rdata is the same as in R6.
- R8: bus_spec is 1 until the request is nonspeculative. A request is nonspeculative when req_nonspec was 1 at acceptance, or when a commit pulse arrived in an earlier cycle. Once bus_spec has gone to 0 for a request, it stays 0.
- R9: A request accepted with req_guard = 1 while still speculative raises no bus_valid until the cycle after a commit pulse. All of its pieces then go out with bus_spec = 0.
- R10: The cycle after the last piece is acknowledged, rsp_valid is 1 for exactly one cycle with rsp_err = 0. A piece acknowledged with bus_err = 1 ends the sequence at once: no further pieces go out, and the response follows in the next cycle with rsp_err = 1.
- R11: req_ready is 0 from the cycle after acceptance until the response cycle, in which it is 1 again. While bus_valid is 1 and bus_ready is 0, the address, size and write data stay unchanged.
- R12: The first piece is offered in the cycle after acceptance, unless R9 holds it back. Each later piece is offered in the cycle right after the previous one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Request size code (R2) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Right-justified store value |
| req_nonspec | input | 1 | Request already nonspeculative at acceptance |
| req_guard | input | 1 | Request may only reach the bus once nonspeculative |
| insn_commit | input | 1 | Pulse: owning instruction is now nonspeculative |
| bus_valid | output | 1 | Bus transfer offered |
| bus_ready | input | 1 | Bus acknowledges the offered transfer |
| bus_addr | output | ADDR_W | Aligned transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_spec | output | 1 | Transfer is speculative |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_err | input | 1 | Error on the acknowledged transfer |
| rsp_valid | output | 1 | One-cycle completion response |
| rsp_rdata | output | 32 | Merged load result |
| rsp_err | output | 1 | A piece of the request ended in error |

## Verification
The hardest states to reach are those where a piece's timing interacts with the speculation state. Examples are a three-piece word whose flag changes between its first and last piece, or a guarded request waiting idle on the bus. The bench reaches these by pulsing the commit input in a chosen cycle of a request. It then compares the flag of each piece against the cycle in which that piece was acknowledged. Error truncation and held transfers are forced by a responder that raises bus_err on a chosen piece or withholds bus_ready for one cycle.

// File: rtl/misalign_pkg.sv
package misalign_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xsize_e;

   // One aligned piece: byte offset from the request address and its size
   typedef struct packed {
      logic [1:0] rel;
      xsize_e     size;
   } piece_t;

   localparam int unsigned MAX_PIECES = 3;

   function automatic xsize_e norm_size(input xsize_e s);
      return (s == SZ_RSVD) ? SZ_WORD : s;
   endfunction

   function automatic logic [2:0] size_bytes(input xsize_e s);
      case (s)
         SZ_BYTE: return 3'd1;
         SZ_HALF: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/misalign_plan.sv
// Fixed split table: number of pieces and the current piece for a request.
module misalign_plan
   import misalign_pkg::*;
(
   input  logic [1:0] off,
   input  logic [1:0] rsize,
   input  logic [1:0] idx,
   output logic [1:0] count,
   output piece_t     cur
);

   piece_t tbl [4];
   xsize_e sz;

   always_comb begin
      sz = norm_size(xsize_e'(rsize));
      for (int i = 0; i < 4; i++) begin
         tbl[i] = '{rel: 2'd0, size: SZ_BYTE};
      end
      count = 2'd1;
      unique case (sz)
         SZ_BYTE: begin
            tbl[0] = '{rel: 2'd0, size: SZ_BYTE};
         end
         SZ_HALF: begin
            if (off[0] == 1'b0) begin
               tbl[0] = '{rel: 2'd0, size: SZ_HALF};
            end else begin
               count  = 2'd2;
               tbl[0] = '{rel: 2'd0, size: SZ_BYTE};
               tbl[1] = '{rel: 2'd1, size: SZ_BYTE};
            end
         end
         default: begin
            case (off)
               2'd0: tbl[0] = '{rel: 2'd0, size: SZ_WORD};
               2'd2: begin
                  count  = 2'd2;
                  tbl[0] = '{rel: 2'd0, size: SZ_HALF};
                  tbl[1] = '{rel: 2'd2, size: SZ_HALF};
               end
               default: begin
                  count  = 2'd3;
                  tbl[0] = '{rel: 2'd0, size: SZ_BYTE};
                  tbl[1] = '{rel: 2'd1, size: SZ_HALF};
                  tbl[2] = '{rel: 2'd3, size: SZ_BYTE};
               end
            endcase
         end
      endcase
      cur = tbl[idx];
   end

endmodule

// File: rtl/misalign_lanes.sv
// Big-endian byte steering for stores and byte gathering for loads.
module misalign_lanes
   import misalign_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [1:0]        paddr_lo,
   input  piece_t            pc,
   input  logic [1:0]        rsize,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] lane_wdata,
   output logic [DATA_W-1:0] ld_bits
);

   localparam int unsigned LANES = DATA_W / 8;

   logic [2:0] plen;
   logic [2:0] nbytes;
   logic [LANES*DATA_W-1:0] r_flat;

   assign plen   = size_bytes(pc.size);
   assign nbytes = size_bytes(norm_size(xsize_e'(rsize)));

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic [2:0]        j;
      logic [2:0]        k;
      logic [2:0]        pos;
      logic              hit;
      logic [7:0]        wbyte;
      logic [DATA_W-1:0] rpart;

      always_comb begin
         j     = 3'(L) - {1'b0, paddr_lo};
         hit   = (3'(L) >= {1'b0, paddr_lo}) && (j < plen);
         k     = {1'b0, pc.rel} + j;
         pos   = nbytes - 3'd1 - k;
         wbyte = hit ? wdata[8*pos[1:0] +: 8] : 8'h00;
         rpart = hit ? (DATA_W'(rdata[8*(LANES-1-L) +: 8]) << (8*pos[1:0]))
                     : '0;
      end

      assign lane_wdata[8*(LANES-1-L) +: 8]  = wbyte;
      assign r_flat[L*DATA_W +: DATA_W]      = rpart;
   end

   always_comb begin
      ld_bits = '0;
      for (int i = 0; i < LANES; i++) begin
         ld_bits = ld_bits | r_flat[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/misalign_seq.sv
// Request capture, piece sequencing, speculation tracking and response.
module misalign_seq
   import misalign_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter bit          COMMIT_BYPASS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_nonspec,
   input  logic              req_guard,
   input  logic              insn_commit,
   input  logic [1:0]        count,
   input  piece_t            pc,
   input  logic [DATA_W-1:0] ld_bits,
   output logic [ADDR_W-1:0] addr_q,
   output logic [1:0]        size_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [1:0]        idx_q,
   output logic              bus_valid,
   input  logic              bus_ready,
   input  logic              bus_err,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic              bus_write,
   output logic              bus_spec,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              guard_q,
   output logic              last_piece
);

   logic busy_q;
   logic write_q;
   logic nonspec_q;
   logic rsp_valid_q;
   logic rsp_err_q;
   logic [DATA_W-1:0] acc_q;
   logic nonspec_now;
   logic accept;
   logic ack;
   logic finish;

   if (COMMIT_BYPASS) begin : g_bypass
      assign nonspec_now = nonspec_q | insn_commit;
   end else begin : g_registered
      assign nonspec_now = nonspec_q;
   end

   assign req_ready  = !busy_q;
   assign accept     = req_valid && req_ready;
   assign bus_valid  = busy_q && (!guard_q || nonspec_now);
   assign ack        = bus_valid && bus_ready;
   assign last_piece = (idx_q == (count - 2'd1));
   assign finish     = ack && (last_piece || bus_err);

   assign bus_addr  = addr_q + ADDR_W'(pc.rel);
   assign bus_size  = pc.size;
   assign bus_write = write_q;
   assign bus_spec  = !nonspec_now;

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = acc_q;
   assign rsp_err   = rsp_err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         write_q     <= 1'b0;
         nonspec_q   <= 1'b0;
         guard_q     <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         acc_q       <= '0;
         addr_q      <= '0;
         size_q      <= 2'd0;
         wdata_q     <= '0;
         idx_q       <= 2'd0;
      end else begin
         rsp_valid_q <= finish;
         if (accept) begin
            busy_q    <= 1'b1;
            addr_q    <= req_addr;
            size_q    <= req_size;
            write_q   <= req_write;
            wdata_q   <= req_wdata;
            nonspec_q <= req_nonspec || insn_commit;
            guard_q   <= req_guard;
            idx_q     <= 2'd0;
            acc_q     <= '0;
            rsp_err_q <= 1'b0;
         end else if (busy_q) begin
            if (insn_commit) begin
               nonspec_q <= 1'b1;
            end
            if (ack) begin
               if (!write_q && !bus_err) begin
                  acc_q <= acc_q | ld_bits;
               end
               if (finish) begin
                  busy_q    <= 1'b0;
                  rsp_err_q <= bus_err;
               end else begin
                  idx_q <= idx_q + 2'd1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
   import misalign_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter bit          COMMIT_BYPASS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_nonspec,
   input  logic              req_guard,
   input  logic              insn_commit,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_size,
   output logic              bus_write,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_spec,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_err,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("misalign_splitter: DATA_W must be 32");
   end
   if (ADDR_W < 3 || ADDR_W > 64) begin : g_bad_addr_w
      $error("misalign_splitter: ADDR_W must lie in 3..64");
   end

   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        size_q;
   logic [DATA_W-1:0] wdata_q;
   logic [1:0]        idx_q;
   logic [1:0]        count;
   piece_t            pc;
   logic [DATA_W-1:0] ld_bits;
   logic              guard_q;
   logic              last_piece;

   misalign_plan plan_i (
      .off   (addr_q[1:0]),
      .rsize (size_q),
      .idx   (idx_q),
      .count (count),
      .cur   (pc)
   );

   misalign_lanes #(.DATA_W(DATA_W)) lanes_i (
      .paddr_lo   (bus_addr[1:0]),
      .pc         (pc),
      .rsize      (size_q),
      .wdata      (wdata_q),
      .rdata      (bus_rdata),
      .lane_wdata (bus_wdata),
      .ld_bits    (ld_bits)
   );

   misalign_seq #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .COMMIT_BYPASS (COMMIT_BYPASS)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .req_size    (req_size),
      .req_write   (req_write),
      .req_wdata   (req_wdata),
      .req_nonspec (req_nonspec),
      .req_guard   (req_guard),
      .insn_commit (insn_commit),
      .count       (count),
      .pc          (pc),
      .ld_bits     (ld_bits),
      .addr_q      (addr_q),
      .size_q      (size_q),
      .wdata_q     (wdata_q),
      .idx_q       (idx_q),
      .bus_valid   (bus_valid),
      .bus_ready   (bus_ready),
      .bus_err     (bus_err),
      .bus_addr    (bus_addr),
      .bus_size    (bus_size),
      .bus_write   (bus_write),
      .bus_spec    (bus_spec),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .rsp_err     (rsp_err),
      .guard_q     (guard_q),
      .last_piece  (last_piece)
   );

endmodule

// File: rtl/misalign_chk.sv
module misalign_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic              bus_err,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_spec,
   input logic              rsp_valid,
   input logic              guard_q,
   input logic              last_piece
);

   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                  && $stable(bus_size) && $stable(bus_wdata));

   // R11
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !req_ready);

   // R2
   natural_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_size != 2'd3)
                    && (bus_size != 2'd1 || !bus_addr[0])
                    && (bus_size != 2'd2 || bus_addr[1:0] == 2'd0));

   // R9
   guard_nonspec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && guard_q |-> !bus_spec);

   // R8
   spec_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_spec |=> !(bus_valid && bus_spec));

   // R12
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && !bus_err && !last_piece |=> bus_valid);

   // R10
   finish_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && (bus_err || last_piece) |=> rsp_valid && !bus_valid);

   // R10
   rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind misalign_splitter misalign_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .bus_valid  (bus_valid),
   .bus_ready  (bus_ready),
   .bus_err    (bus_err),
   .bus_addr   (bus_addr),
   .bus_size   (bus_size),
   .bus_wdata  (bus_wdata),
   .bus_spec   (bus_spec),
   .rsp_valid  (rsp_valid),
   .guard_q    (guard_q),
   .last_piece (last_piece)
);

// File: tb/misalign_splitter_tb_top.sv
module misalign_splitter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        req_nonspec = 1'b0;
   logic        req_guard = 1'b0;
   logic        insn_commit = 1'b0;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic [31:0] bus_addr;
   logic [1:0]  bus_size;
   logic        bus_write;
   logic [31:0] bus_wdata;
   logic        bus_spec;
   logic [31:0] bus_rdata = '0;
   logic        bus_err = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_err;

   int nchk  = 0;
   int nfail = 0;

   logic [7:0]  mem [16];
   logic [31:0] pa  [4];
   logic [1:0]  ps  [4];
   logic        psp [4];
   logic        pw  [4];
   logic [31:0] pwd [4];
   int          pit [4];
   int          npc;
   bit          got_rsp, rsp_e, ready_bad, rdy_rsp, hold_bad;
   logic [31:0] rsp_d;

   always #4 clk = ~clk;   // 125 MHz

   misalign_splitter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .req_nonspec(req_nonspec), .req_guard(req_guard), .insn_commit(insn_commit),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_spec(bus_spec), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Runs one request against a byte-memory responder and records each piece.
   task automatic run_access(input logic [31:0] a, input logic [1:0] sz,
                             input bit wr, input logic [31:0] wd,
                             input bit ns, input bit guard, input int commit_at,
                             input int err_at, input bit stall);
      bit          pend = 0;
      logic [31:0] hold_a = '0;
      npc = 0; got_rsp = 0; rsp_e = 0; rsp_d = '0;
      ready_bad = 0; rdy_rsp = 0; hold_bad = 0;
      req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
      req_wdata = wd; req_nonspec = ns; req_guard = guard;
      @(negedge clk);
      req_valid = 1'b0;
      for (int it = 0; it < 40; it++) begin
         bus_ready = 1'b0; bus_err = 1'b0; insn_commit = 1'b0;
         if (rsp_valid) begin
            got_rsp = 1; rsp_d = rsp_rdata; rsp_e = rsp_err; rdy_rsp = req_ready;
            break;
         end
         if (req_ready) ready_bad = 1;
         if (it == commit_at) insn_commit = 1'b1;
         if (bus_valid) begin
            if (stall && !pend) begin
               pend = 1; hold_a = bus_addr;
            end else begin
               if (pend && bus_addr !== hold_a) hold_bad = 1;
               pend = 0;
               if (npc < 4) begin
                  pa[npc] = bus_addr; ps[npc] = bus_size; psp[npc] = bus_spec;
                  pw[npc] = bus_write; pwd[npc] = bus_wdata; pit[npc] = it;
               end
               for (int L = 0; L < 4; L++)
                  bus_rdata[8*(3-L) +: 8] = mem[((bus_addr & ~32'd3) + L) & 15];
               bus_ready = 1'b1;
               if (npc == err_at) bus_err = 1'b1;
               npc++;
            end
         end
         @(negedge clk);
      end
      bus_ready = 1'b0; bus_err = 1'b0; insn_commit = 1'b0;
   endtask

   // Checks the recorded pieces against a greedy aligned cover of the request.
   task automatic verify(input string shape_req, input logic [31:0] a,
                         input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                         input bit ns, input bit guard, input int commit_at,
                         input int err_at, input bit stall);
      int          n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      logic [31:0] ea [4];
      int          es [4];
      int          ne = 0;
      int          cur = int'(a);
      int          rem = n;
      int          expcnt;
      int          first;
      logic [31:0] expd = '0;
      while (rem > 0) begin
         int s = (cur % 4 == 0 && rem >= 4) ? 4 : (cur % 2 == 0 && rem >= 2) ? 2 : 1;
         ea[ne] = 32'(cur); es[ne] = s; cur += s; rem -= s; ne++;
      end
      expcnt = (err_at >= 0) ? err_at + 1 : ne;
      check(shape_req, "piece count", 32'(npc), 32'(expcnt));
      for (int i = 0; i < npc && i < 4 && i < ne; i++) begin
         check(shape_req, "piece addr", pa[i], ea[i]);
         check(shape_req, "piece size", 32'(ps[i]),
               (es[i] == 1) ? 32'd0 : (es[i] == 2) ? 32'd1 : 32'd2);
         check("R8", "piece spec", 32'(psp[i]),
               32'(!(ns || (commit_at >= 0 && pit[i] > commit_at))));
         if (wr) begin
            check("R6", "bus_write", 32'(pw[i]), 32'd1);
            for (int j = 0; j < es[i]; j++) begin
               int k    = int'(ea[i]) + j - int'(a);
               int lane = (int'(ea[i]) + j) % 4;
               check("R6", "store lane", 32'(pwd[i][8*(3-lane) +: 8]),
                     32'(wd[8*(n-1-k) +: 8]));
            end
         end
         if (i > 0 && !stall)
            check("R12", "back-to-back issue", 32'(pit[i]), 32'(pit[i-1] + 1));
      end
      first = ((guard && !ns) ? commit_at + 1 : 0) + (stall ? 1 : 0);
      if (npc > 0) check(guard ? "R9" : "R12", "first piece cycle", 32'(pit[0]), 32'(first));
      check("R10", "response seen", 32'(got_rsp), 32'd1);
      check("R10", "rsp_err", 32'(rsp_e), 32'(err_at >= 0));
      check("R11", "req_ready low while busy", 32'(ready_bad), 32'd0);
      check("R11", "req_ready in response cycle", 32'(rdy_rsp), 32'd1);
      if (!wr && err_at < 0) begin
         for (int k = 0; k < n; k++) expd[8*(n-1-k) +: 8] = mem[(int'(a) + k) & 15];
         check("R7", "load result", rsp_d, expd);
      end
      @(negedge clk);
   endtask

   task automatic access(input string shape_req, input logic [31:0] a,
                         input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                         input bit ns, input bit guard, input int commit_at,
                         input int err_at, input bit stall);
      run_access(a, sz, wr, wd, ns, guard, commit_at, err_at, stall);
      verify(shape_req, a, sz, wr, wd, ns, guard, commit_at, err_at, stall);
   endtask

   task automatic t_reset;
      check("R1", "req_ready", 32'(req_ready), 32'd1);
      check("R1", "bus_valid", 32'(bus_valid), 32'd0);
      check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_aligned;
      for (int o = 0; o < 4; o++) begin
         access("R2", 32'h8 + 32'(o), 2'd0, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
         access("R2", 32'h8 + 32'(o), 2'd0, 1'b1, 32'h0000_005A + 32'(o), 1'b1, 1'b0, -1, -1, 1'b0);
      end
      for (int o = 0; o < 4; o += 2) begin
         access("R2", 32'h4 + 32'(o), 2'd1, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
         access("R2", 32'h4 + 32'(o), 2'd1, 1'b1, 32'h0000_C3D4, 1'b1, 1'b0, -1, -1, 1'b0);
      end
      access("R2", 32'h4, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R2", 32'h0, 2'd2, 1'b1, 32'h1122_3344, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R2", 32'hC, 2'd3, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
   endtask

   task automatic t_half_split;
      access("R3", 32'h1, 2'd1, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R3", 32'h3, 2'd1, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R3", 32'h3, 2'd1, 1'b1, 32'h0000_ABCD, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R3", 32'h9, 2'd1, 1'b1, 32'h0000_7E81, 1'b1, 1'b0, -1, -1, 1'b0);
   endtask

   task automatic t_word_split;
      access("R4", 32'h2, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R4", 32'h6, 2'd2, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R5", 32'h1, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R5", 32'h3, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R5", 32'h1, 2'd2, 1'b1, 32'hA1B2_C3D4, 1'b1, 1'b0, -1, -1, 1'b0);
      access("R5", 32'h7, 2'd2, 1'b1, 32'h0F1E_2D3C, 1'b1, 1'b0, -1, -1, 1'b0);
   endtask

   task automatic t_spec;
      // R8: commit during the second piece; only the third piece is nonspeculative
      access("R5", 32'h1, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0, 1, -1, 1'b0);
      access("R8", 32'h2, 2'd2, 1'b1, 32'h5566_7788, 1'b0, 1'b0, -1, -1, 1'b0);
   endtask

   task automatic t_guard;
      // R9: guarded request waits for a commit in cycle 3
      access("R5", 32'h3, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1, 3, -1, 1'b0);
      access("R2", 32'h4, 2'd2, 1'b1, 32'h0BAD_F00D, 1'b1, 1'b1, -1, -1, 1'b0);
   endtask

   task automatic t_error;
      // R10: error on the second of three pieces cuts the sequence short
      access("R5", 32'h1, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, 1, 1'b0);
      access("R3", 32'h3, 2'd1, 1'b1, 32'h0000_1357, 1'b1, 1'b0, -1, 0, 1'b0);
      access("R4", 32'h2, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b0);
   endtask

   task automatic t_stall;
      // R11: responder holds bus_ready low one cycle per piece
      access("R5", 32'h3, 2'd2, 1'b1, 32'hCAFE_1234, 1'b1, 1'b0, -1, -1, 1'b1);
      check("R11", "held transfer stable", 32'(hold_bad), 32'd0);
      access("R3", 32'h1, 2'd1, 1'b0, 32'h0, 1'b1, 1'b0, -1, -1, 1'b1);
      check("R11", "held transfer stable", 32'(hold_bad), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned();
      t_half_split();
      t_word_split();
      t_spec();
      t_guard();
      t_error();
      t_stall();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule